// File: doc/BRIEF.md
# Enable-Paced SPI Master for a 16-bit ADC and DAC

This block is a serial-peripheral master that talks to two converters: a 16-bit analog-to-digital converter that it reads and a 16-bit digital-to-analog converter that it writes. Every flip-flop runs on the one system clock. A free-running counter with a terminal-count compare sets the serial timing. Its square-wave output reaches the serial clock pin only while a transfer is on. Its strobes tell the transfer engine when to launch and when to capture. No logic is clocked from a divided net.

A host starts a transfer with a one-cycle `start`, choosing the converter with `dev_sel`. A DAC write drives `tx_data` out MSB first as soon as the select falls. An ADC read first holds the select low for a fixed number of idle serial periods. It then takes in one unbroken 16-bit word, which lands in `rx_data`. `busy` covers the whole transfer. `done` pulses once as the select is released.

Top module: `spi_conv_if`

## Requirements
- R1: After a synchronous active-high `rst`, both `adc_cs_n` and `dac_cs_n` are high, `sclk` and `mosi` are low, `busy` and `done` are low and `rx_data` is zero.
- R2: While a select is low and the serial clock is running, `sclk` has a period of DIV_RATIO system clocks (32 by default) and is high for exactly DIV_RATIO/2 of them.
- R3: With `dev_sel`=1 (ADC read), `adc_cs_n` goes low and `sclk` then gives ADC_WAIT (5) full periods that carry no data. It then gives 16 more periods with no gap, for 21 pulses in all.
- R4: On an ADC read, `miso` is sampled on each falling `sclk` edge of the 16 data periods. The first bit sampled becomes `rx_data[15]` and the last becomes `rx_data[0]`. The whole word appears together when `done` pulses.
- R5: With `dev_sel`=0 (DAC write), `dac_cs_n` goes low and 16 `sclk` pulses follow at once. `mosi` changes only on rising `sclk` edges and carries `tx_data` MSB first, so it is valid at each falling edge. `adc_cs_n` stays high.
- R6: A `start` that arrives while `busy` is high is ignored. The running transfer keeps its device and data, and no second transfer follows.
- R7: `done` is high for exactly one cycle per transfer. In that cycle `busy` is already low and both selects are high.
- R8: The active select rises DIV_RATIO system clocks (one serial period) after the last falling `sclk` edge. `sclk` is low whenever both selects are high, and the two selects are never low together.
- R9: A DAC write leaves `rx_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; clocks every register |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a transfer |
| dev_sel | input | 1 | 1 = ADC read, 0 = DAC write; sampled with `start` |
| tx_data | input | 16 | Word sent to the DAC; sampled with `start` |
| rx_data | output | 16 | Last word read from the ADC |
| busy | output | 1 | High from an accepted `start` until the select is released |
| done | output | 1 | One-cycle pulse at the end of each transfer |
| sclk | output | 1 | Serial clock pin, low when idle |
| mosi | output | 1 | Serial data to the DAC |
| miso | input | 1 | Serial data from the ADC |
| adc_cs_n | output | 1 | Active-low ADC select |
| dac_cs_n | output | 1 | Active-low DAC select |

## Verification
The bench plays both converters. It drives ADC bits only after the fifth rising edge and records `mosi` on falling edges. A design that skipped or added wait periods, or split the word, would return a shifted word or the wrong pulse count. Patterns with the MSB and LSB set catch reversed bit order and lost end bits. The bench times the select release against the last falling edge, and a design that released the select early or late would show up there. A second `start` with the other device mid-read must leave the DAC select untouched and must not queue a later transfer.

// File: rtl/spi_conv_pkg.sv
package spi_conv_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ALIGN,
      ST_WAIT,
      ST_SHIFT,
      ST_TAIL
   } xfer_state_t;

   typedef enum logic {
      DEV_DAC = 1'b0,
      DEV_ADC = 1'b1
   } conv_dev_t;
endpackage

// File: rtl/spi_en_div.sv
module spi_en_div #(
   parameter int DIV_RATIO = 32
) (
   input  logic clk,
   input  logic rst,
   output logic rise_stb,
   output logic tc_stb,
   output logic sq
);
   localparam int CW   = $clog2(DIV_RATIO);
   localparam int HALF = DIV_RATIO / 2;

   logic [CW-1:0] cnt_q;

   assign rise_stb = (cnt_q == CW'(HALF - 1));
   assign tc_stb   = (cnt_q == CW'(DIV_RATIO - 1));

   always_ff @(posedge clk) begin
      if (rst)          cnt_q <= '0;
      else if (tc_stb)  cnt_q <= '0;
      else              cnt_q <= cnt_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst)           sq <= 1'b0;
      else if (rise_stb) sq <= 1'b1;
      else if (tc_stb)   sq <= 1'b0;
   end
endmodule

// File: rtl/spi_xfer_fsm.sv
module spi_xfer_fsm
   import spi_conv_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int ADC_WAIT = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rise_stb,
   input  logic              tc_stb,
   input  logic              start,
   input  logic              dev_sel,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              miso,
   output logic [DATA_W-1:0] rx_data,
   output logic              busy,
   output logic              done,
   output logic              mosi,
   output logic              adc_cs_n,
   output logic              dac_cs_n,
   output logic              clk_on
);
   localparam int  BW       = $clog2(DATA_W);
   localparam bit  HAS_WAIT = (ADC_WAIT > 0);

   xfer_state_t       state_q;
   conv_dev_t         dev_q;
   logic [DATA_W-1:0] tx_sh;
   logic [DATA_W-1:0] rx_sh;
   logic [BW-1:0]     bit_q;
   logic              wait_last;

   generate
      if (HAS_WAIT) begin : g_wait
         localparam int WW = $clog2(ADC_WAIT + 1);
         logic [WW-1:0] wcnt_q;
         always_ff @(posedge clk) begin
            if (rst || state_q != ST_WAIT) wcnt_q <= '0;
            else if (tc_stb)               wcnt_q <= wcnt_q + 1'b1;
         end
         assign wait_last = (wcnt_q == WW'(ADC_WAIT - 1));
      end else begin : g_nowait
         assign wait_last = 1'b1;
      end
   endgenerate

   assign busy   = (state_q != ST_IDLE);
   assign clk_on = (state_q == ST_WAIT) || (state_q == ST_SHIFT);

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q  <= ST_IDLE;
         dev_q    <= DEV_DAC;
         tx_sh    <= '0;
         rx_sh    <= '0;
         rx_data  <= '0;
         bit_q    <= '0;
         done     <= 1'b0;
         mosi     <= 1'b0;
         adc_cs_n <= 1'b1;
         dac_cs_n <= 1'b1;
      end else begin
         done <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  dev_q   <= conv_dev_t'(dev_sel);
                  tx_sh   <= tx_data;
                  state_q <= ST_ALIGN;
               end
            end
            ST_ALIGN: begin
               if (tc_stb) begin
                  bit_q <= '0;
                  if (dev_q == DEV_ADC) begin
                     adc_cs_n <= 1'b0;
                     state_q  <= HAS_WAIT ? ST_WAIT : ST_SHIFT;
                  end else begin
                     dac_cs_n <= 1'b0;
                     state_q  <= ST_SHIFT;
                  end
               end
            end
            ST_WAIT: begin
               if (tc_stb && wait_last) state_q <= ST_SHIFT;
            end
            ST_SHIFT: begin
               if (rise_stb) begin
                  mosi  <= tx_sh[DATA_W-1];
                  tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
               end
               if (tc_stb) begin
                  rx_sh <= {rx_sh[DATA_W-2:0], miso};
                  bit_q <= bit_q + 1'b1;
                  if (bit_q == BW'(DATA_W - 1)) state_q <= ST_TAIL;
               end
            end
            ST_TAIL: begin
               if (tc_stb) begin
                  adc_cs_n <= 1'b1;
                  dac_cs_n <= 1'b1;
                  mosi     <= 1'b0;
                  done     <= 1'b1;
                  if (dev_q == DEV_ADC) rx_data <= rx_sh;
                  state_q  <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/spi_conv_if.sv
module spi_conv_if #(
   parameter int DIV_RATIO   = 32,
   parameter int DATA_W      = 16,
   parameter int ADC_WAIT    = 5,
   parameter int SYS_HZ      = 48_000_000,
   parameter int MAX_SCLK_HZ = 2_900_000
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              dev_sel,
   input  logic [DATA_W-1:0] tx_data,
   output logic [DATA_W-1:0] rx_data,
   output logic              busy,
   output logic              done,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso,
   output logic              adc_cs_n,
   output logic              dac_cs_n
);
   generate
      if (DIV_RATIO < 4 || (DIV_RATIO % 2) != 0) begin : g_bad_div
         $error("DIV_RATIO must be even and at least 4");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must be at least 2");
      end
      if ((SYS_HZ / DIV_RATIO) > MAX_SCLK_HZ) begin : g_bad_rate
         $error("serial clock would exceed MAX_SCLK_HZ");
      end
   endgenerate

   logic rise_stb;
   logic tc_stb;
   logic sq;
   logic clk_on;

   spi_en_div #(.DIV_RATIO(DIV_RATIO)) u_div (
      .clk      (clk),
      .rst      (rst),
      .rise_stb (rise_stb),
      .tc_stb   (tc_stb),
      .sq       (sq)
   );

   spi_xfer_fsm #(.DATA_W(DATA_W), .ADC_WAIT(ADC_WAIT)) u_fsm (
      .clk      (clk),
      .rst      (rst),
      .rise_stb (rise_stb),
      .tc_stb   (tc_stb),
      .start    (start),
      .dev_sel  (dev_sel),
      .tx_data  (tx_data),
      .miso     (miso),
      .rx_data  (rx_data),
      .busy     (busy),
      .done     (done),
      .mosi     (mosi),
      .adc_cs_n (adc_cs_n),
      .dac_cs_n (dac_cs_n),
      .clk_on   (clk_on)
   );

   assign sclk = sq & clk_on;
endmodule

// File: rtl/spi_conv_if_chk.sv
module spi_conv_if_chk (
   input logic clk,
   input logic rst,
   input logic busy,
   input logic done,
   input logic sclk,
   input logic adc_cs_n,
   input logic dac_cs_n
);
   // R8: the two selects never overlap
   p_cs_excl_r8: assert property (@(posedge clk) disable iff (rst)
      !(!adc_cs_n && !dac_cs_n));

   // R8: serial clock idles low with no select
   p_sclk_idle_r8: assert property (@(posedge clk) disable iff (rst)
      (adc_cs_n && dac_cs_n) |-> !sclk);

   // R7: done lasts one cycle
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   // R7: at done the block is idle and released
   p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
      done |-> (!busy && adc_cs_n && dac_cs_n));

   // R6: a select is only ever low inside a busy window
   p_cs_in_busy_r6: assert property (@(posedge clk) disable iff (rst)
      (!adc_cs_n || !dac_cs_n) |-> busy);

   // R3: selects fall only after busy was already high
   p_cs_after_start_r3: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> (adc_cs_n && dac_cs_n));
endmodule

bind spi_conv_if spi_conv_if_chk u_chk (
   .clk      (clk),
   .rst      (rst),
   .busy     (busy),
   .done     (done),
   .sclk     (sclk),
   .adc_cs_n (adc_cs_n),
   .dac_cs_n (dac_cs_n)
);

// File: tb/spi_conv_if_bench.sv
module spi_conv_if_bench;
   timeunit 1ns;
   timeprecision 1ns;

   localparam int DIV  = 32;
   localparam int DW   = 16;
   localparam int WAIT = 5;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          start = 1'b0;
   logic          dev_sel = 1'b0;
   logic [DW-1:0] tx_data = '0;
   logic [DW-1:0] rx_data;
   logic          busy, done, sclk, mosi, adc_cs_n, dac_cs_n;
   logic          miso = 1'b0;

   spi_conv_if #(.DIV_RATIO(DIV), .DATA_W(DW), .ADC_WAIT(WAIT)) u_spi_conv_if (
      .clk(clk), .rst(rst), .start(start), .dev_sel(dev_sel),
      .tx_data(tx_data), .rx_data(rx_data), .busy(busy), .done(done),
      .sclk(sclk), .mosi(mosi), .miso(miso),
      .adc_cs_n(adc_cs_n), .dac_cs_n(dac_cs_n)
   );

   always #5 clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;

   // converter model state
   int            rises, falls, done_cnt, sclk_idle_bad;
   logic [DW-1:0] pat, cap;
   longint        last_rise, prev_rise, last_fall, hi_t, cs_rise_t;
   bit            adc_seen, dac_seen;

   always @(posedge sclk) begin
      prev_rise = last_rise;
      last_rise = $time;
      rises++;
      if (!adc_cs_n && rises > WAIT && rises <= WAIT + DW)
         miso = pat[DW + WAIT - rises];
   end

   always @(negedge sclk) begin
      falls++;
      last_fall = $time;
      hi_t = $time - last_rise;
      if (!dac_cs_n) cap = {cap[DW-2:0], mosi};
   end

   always @(posedge adc_cs_n or posedge dac_cs_n) cs_rise_t = $time;
   always @(negedge adc_cs_n) adc_seen = 1'b1;
   always @(negedge dac_cs_n) dac_seen = 1'b1;

   always @(posedge clk) begin
      if (!rst && adc_cs_n && dac_cs_n && sclk) sclk_idle_bad++;
      if (!rst && done) done_cnt++;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic clear_model();
      rises = 0; falls = 0; done_cnt = 0; cap = '0;
      adc_seen = 1'b0; dac_seen = 1'b0; miso = 1'b0;
   endtask

   task automatic pulse_start(input logic dev, input logic [DW-1:0] d);
      @(negedge clk);
      start = 1'b1; dev_sel = dev; tx_data = d;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done(input string req);
      bit seen = 1'b0;
      for (int i = 0; i < 4000 && !seen; i++) begin
         @(negedge clk);
         if (done) seen = 1'b1;
      end
      chk(seen, req, "done seen", seen, 1);
      if (seen) begin
         chk(!busy && adc_cs_n && dac_cs_n, "R7", "idle at done",
             {busy, adc_cs_n, dac_cs_n}, 3'b011);
         @(negedge clk);
         chk(!done, "R7", "done width", done, 0);
      end
   endtask

   task automatic t_reset();
      chk(adc_cs_n && dac_cs_n, "R1", "selects", {adc_cs_n, dac_cs_n}, 2'b11);
      chk(!sclk && !mosi, "R1", "sclk/mosi", {sclk, mosi}, 0);
      chk(!busy && !done, "R1", "busy/done", {busy, done}, 0);
      chk(rx_data == '0, "R1", "rx_data", rx_data, 0);
   endtask

   task automatic t_adc(input logic [DW-1:0] p);
      clear_model();
      pat = p;
      pulse_start(1'b1, 16'h0000);
      wait_done("R3");
      chk(rx_data == p, "R4", "rx word", rx_data, p);
      chk(rises == WAIT + DW && falls == WAIT + DW, "R3", "pulse count",
          rises, WAIT + DW);
      chk(!dac_seen && adc_seen, "R3", "adc select only", {adc_seen, dac_seen}, 2'b10);
      chk(last_rise - prev_rise == DIV * 10, "R2", "period ns",
          last_rise - prev_rise, DIV * 10);
      chk(hi_t == DIV * 5, "R2", "high ns", hi_t, DIV * 5);
      chk(cs_rise_t - last_fall == DIV * 10, "R8", "release delay ns",
          cs_rise_t - last_fall, DIV * 10);
      chk(done_cnt == 1, "R7", "done count", done_cnt, 1);
   endtask

   task automatic t_dac(input logic [DW-1:0] d, input logic [DW-1:0] rx_before);
      clear_model();
      pulse_start(1'b0, d);
      wait_done("R5");
      chk(cap == d, "R5", "dac word", cap, d);
      chk(falls == DW, "R5", "pulse count", falls, DW);
      chk(!adc_seen && dac_seen, "R5", "dac select only", {adc_seen, dac_seen}, 2'b01);
      chk(cs_rise_t - last_fall == DIV * 10, "R8", "release delay ns",
          cs_rise_t - last_fall, DIV * 10);
      chk(rx_data == rx_before, "R9", "rx unchanged", rx_data, rx_before);
   endtask

   task automatic t_start_busy(input logic [DW-1:0] p);
      clear_model();
      pat = p;
      pulse_start(1'b1, 16'h0000);
      repeat (300) @(negedge clk);
      chk(busy, "R6", "busy mid read", busy, 1);
      pulse_start(1'b0, 16'h1234);
      wait_done("R6");
      chk(rx_data == p, "R6", "rx kept", rx_data, p);
      repeat (400) @(negedge clk);
      chk(!busy && !dac_seen, "R6", "no queued transfer", {busy, dac_seen}, 0);
      chk(done_cnt == 1, "R6", "done count", done_cnt, 1);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst = 1'b0;
      sclk_idle_bad = 0;
      @(negedge clk);
      t_reset();
      t_adc(16'hA5C3);
      t_adc(16'h8001);
      t_dac(16'h3C96, 16'h8001);
      t_dac(16'h7FFE, 16'h8001);
      t_start_busy(16'h5AA5);
      t_adc(16'hFFFF);
      chk(sclk_idle_bad == 0, "R8", "sclk high while idle", sclk_idle_bad, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule